// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache Controller

This block sits between a processor that issues single-byte loads and stores on a 24-bit byte address and a memory that moves whole 32-bit blocks. Each block of four bytes maps to exactly one set, chosen by the address bits just above the byte offset. It may live in either of the two ways of that set. A lookup compares the stored tags of both ways with the tag field of the address. A hit is served from the local line store with no memory traffic. A miss picks a victim way and, when that line has been modified, first writes it back to memory. It then fetches the missing block and installs it. Only after the fill does it answer the processor. A store that misses allocates the block in the same way and then merges its byte into the fetched word.

The processor side accepts one request per transaction while `cpu_ready` is high, and reports completion with a one-cycle `cpu_done` pulse that carries the read byte. The memory side raises a request with a direction, a block address and write data, holds them until `mem_ready` is seen, and for reads waits for a separate `mem_rvalid` beat. The number of sets is a parameter. The full-size configuration uses `SET_W = 13`, giving 8192 sets × 2 ways × 4 bytes = 64 KB and a 9-bit tag. The default is a smaller 64-set build so that the storage stays small.

Top module: `cache2w_top`

## Requirements
- R1: After synchronous reset every way of every set is invalid and clean, `cpu_ready` is 1, `mem_req` is 0 and `cpu_done` is 0.
- R2: A hit causes no memory request. `cpu_done` pulses for exactly one cycle, two cycles after the cycle in which the request was accepted, and a read returns the byte most recently stored at that address.
- R3: A read miss issues one memory read of block address `cpu_addr[23:2]`, installs the block, and only then returns the requested byte, selected by `cpu_addr[1:0]` (byte 0 in data bits 7:0).
- R4: Both ways of a set are usable. A miss fills an invalid way, way 0 first, before any valid way is evicted, so two blocks that share a set are both resident afterwards.
- R5: When both ways are valid, the victim is the way that was not most recently accessed. Both hits and fills count as accesses.
- R6: A store updates only the cached line and marks it dirty, with no memory write. A clean victim is replaced without any memory write.
- R7: A store that misses fetches the block first, then merges the byte. The other three bytes of the block keep their memory values.
- R8: A dirty victim is written back to its own block address (stored tag and set) with its current contents, and this write happens before the fetch of the new block.
- R9: A memory request keeps its address and direction stable while `mem_ready` is low. Read data is taken only on `mem_rvalid`. No memory request is raised while the controller is idle.
- R10: The address splits into the byte offset `[1:0]`, the set index in the next `SET_W` bits, and the tag in the remaining high bits. Blocks that differ only in the set field never evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, taken while cpu_ready is high |
| cpu_we | input | 1 | 1 = byte store, 0 = byte load |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_ready | output | 1 | Controller idle and able to accept a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Load result, valid with cpu_done |
| mem_req | output | 1 | Memory block request |
| mem_we | output | 1 | 1 = block write-back, 0 = block fetch |
| mem_addr | output | 22 | Block address (byte address bits 23:2) |
| mem_wdata | output | 32 | Write-back block data |
| mem_ready | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | Fetched block data valid |
| mem_rdata | input | 32 | Fetched block data |

## Verification
The directed part concentrates on a single set. It uses a cold read, a repeated read of the same block, and a second block with a different tag. That tells fetch from hit and invalid-way filling from eviction. A third and a fourth tag are then introduced after chosen access orders, and the block that must be re-fetched shows whether the victim followed recency. A store followed by a conflicting miss separates the clean-victim case from the dirty one. In the dirty case the recorded memory operations give the write-back's address, data and position before the fetch. A store miss read back at all four offsets, blocks with one tag in neighbouring sets, and a long pseudo-random mix of loads and stores over a few conflicting tags then compare every load against a flat byte model of memory.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    localparam int ADDR_W     = 24;
    localparam int OFF_W      = 2;
    localparam int LINE_BYTES = 1 << OFF_W;
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int WAYS       = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WBACK,
        ST_FETCH,
        ST_FILL
    } ctrl_state_e;

    typedef logic [LINE_W-1:0] line_t;

    function automatic logic [7:0] line_get_byte(line_t line, logic [OFF_W-1:0] off);
        return line[off*8 +: 8];
    endfunction

    function automatic line_t line_put_byte(line_t line, logic [OFF_W-1:0] off, logic [7:0] b);
        line_t res;
        res = line;
        res[off*8 +: 8] = b;
        return res;
    endfunction

endpackage

// File: rtl/cache2w_tag_store.sv
module cache2w_tag_store
    import cache2w_pkg::*;
#(
    parameter int SET_W = 6,
    parameter int TAG_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [SET_W-1:0]            set_idx,
    output logic [WAYS-1:0]             rd_valid,
    output logic [WAYS-1:0]             rd_dirty,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic                        rd_lru,
    input  logic                        wr_en,
    input  logic                        wr_way,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic                        wr_dirty,
    input  logic                        lru_we,
    input  logic                        lru_val
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0] lru_q;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0]  valid_q;
        logic [SETS-1:0]  dirty_q;
        logic [TAG_W-1:0] tag_q [SETS];

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q <= '0;
                dirty_q <= '0;
            end else if (wr_en && (wr_way == w[0])) begin
                valid_q[set_idx] <= 1'b1;
                dirty_q[set_idx] <= wr_dirty;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == w[0])) begin
                tag_q[set_idx] <= wr_tag;
            end
        end

        assign rd_valid[w] = valid_q[set_idx];
        assign rd_dirty[w] = dirty_q[set_idx];
        assign rd_tag[w]   = tag_q[set_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lru_q <= '0;
        end else if (lru_we) begin
            lru_q[set_idx] <= lru_val;
        end
    end

    assign rd_lru = lru_q[set_idx];

endmodule

// File: rtl/cache2w_data_store.sv
module cache2w_data_store
    import cache2w_pkg::*;
#(
    parameter int SET_W = 6
) (
    input  logic                    clk,
    input  logic [SET_W-1:0]        set_idx,
    output logic [WAYS-1:0][LINE_W-1:0] rd_line,
    input  logic                    wr_en,
    input  logic                    wr_way,
    input  line_t                   wr_line
);
    localparam int SETS = 1 << SET_W;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        line_t mem_q [SETS];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == w[0])) begin
                mem_q[set_idx] <= wr_line;
            end
        end

        assign rd_line[w] = mem_q[set_idx];
    end

endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
    import cache2w_pkg::*;
#(
    parameter int SET_W = 6,
    parameter int TAG_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cpu_req,
    input  logic                        cpu_we,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic [7:0]                  cpu_wdata,
    output logic                        cpu_ready,
    output logic                        cpu_done,
    output logic [7:0]                  cpu_rdata,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [TAG_W+SET_W-1:0]      mem_addr,
    output line_t                       mem_wdata,
    input  logic                        mem_ready,
    input  logic                        mem_rvalid,
    input  line_t                       mem_rdata,
    output logic [SET_W-1:0]            set_idx,
    input  logic [WAYS-1:0]             rd_valid,
    input  logic [WAYS-1:0]             rd_dirty,
    input  logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    input  logic                        rd_lru,
    input  logic [WAYS-1:0][LINE_W-1:0] rd_line,
    output logic                        tw_en,
    output logic                        tw_way,
    output logic [TAG_W-1:0]            tw_tag,
    output logic                        tw_dirty,
    output logic                        lru_we,
    output logic                        lru_val,
    output logic                        dw_en,
    output logic                        dw_way,
    output line_t                       dw_line
);
    ctrl_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic [7:0]        wdata_q;
    logic              victim_q, victim_d;
    logic              done_q, done_d;
    logic [7:0]        rdata_q, rdata_d;

    logic [TAG_W-1:0]  req_tag;
    logic [OFF_W-1:0]  req_off;
    logic [WAYS-1:0]   hit_vec;
    logic              hit;
    logic              hit_way;
    line_t             hit_line;
    line_t             fill_line;

    assign req_off = addr_q[OFF_W-1:0];
    assign set_idx = addr_q[OFF_W +: SET_W];
    assign req_tag = addr_q[ADDR_W-1 -: TAG_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = rd_valid[w] && (rd_tag[w] == req_tag);
    end

    assign hit       = |hit_vec;
    assign hit_way   = hit_vec[1];
    assign hit_line  = rd_line[hit_way];
    assign fill_line = we_q ? line_put_byte(mem_rdata, req_off, wdata_q) : mem_rdata;

    always_comb begin
        state_d   = state_q;
        victim_d  = victim_q;
        done_d    = 1'b0;
        rdata_d   = rdata_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {req_tag, set_idx};
        mem_wdata = rd_line[victim_q];
        tw_en     = 1'b0;
        tw_way    = 1'b0;
        tw_tag    = req_tag;
        tw_dirty  = 1'b0;
        lru_we    = 1'b0;
        lru_val   = 1'b0;
        dw_en     = 1'b0;
        dw_way    = 1'b0;
        dw_line   = hit_line;

        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (hit) begin
                    lru_we  = 1'b1;
                    lru_val = ~hit_way;
                    done_d  = 1'b1;
                    rdata_d = line_get_byte(hit_line, req_off);
                    if (we_q) begin
                        dw_en    = 1'b1;
                        dw_way   = hit_way;
                        dw_line  = line_put_byte(hit_line, req_off, wdata_q);
                        tw_en    = 1'b1;
                        tw_way   = hit_way;
                        tw_dirty = 1'b1;
                    end
                    state_d = ST_IDLE;
                end else begin
                    if (!rd_valid[0])      victim_d = 1'b0;
                    else if (!rd_valid[1]) victim_d = 1'b1;
                    else                   victim_d = rd_lru;
                    state_d = (rd_valid[victim_d] && rd_dirty[victim_d]) ? ST_WBACK : ST_FETCH;
                end
            end
            ST_WBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {rd_tag[victim_q], set_idx};
                if (mem_ready) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                mem_req = 1'b1;
                if (mem_ready) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (mem_rvalid) begin
                    dw_en    = 1'b1;
                    dw_way   = victim_q;
                    dw_line  = fill_line;
                    tw_en    = 1'b1;
                    tw_way   = victim_q;
                    tw_dirty = we_q;
                    lru_we   = 1'b1;
                    lru_val  = ~victim_q;
                    done_d   = 1'b1;
                    rdata_d  = line_get_byte(fill_line, req_off);
                    state_d  = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            victim_q <= 1'b0;
            done_q   <= 1'b0;
            rdata_q  <= '0;
            addr_q   <= '0;
            we_q     <= 1'b0;
            wdata_q  <= '0;
        end else begin
            state_q  <= state_d;
            victim_q <= victim_d;
            done_q   <= done_d;
            rdata_q  <= rdata_d;
            if (state_q == ST_IDLE && cpu_req) begin
                addr_q  <= cpu_addr;
                we_q    <= cpu_we;
                wdata_q <= cpu_wdata;
            end
        end
    end

    assign cpu_ready = (state_q == ST_IDLE);
    assign cpu_done  = done_q;
    assign cpu_rdata = rdata_q;

endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
    import cache2w_pkg::*;
#(
    parameter int SET_W = 6
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             cpu_req,
    input  logic                             cpu_we,
    input  logic [ADDR_W-1:0]                cpu_addr,
    input  logic [7:0]                       cpu_wdata,
    output logic                             cpu_ready,
    output logic                             cpu_done,
    output logic [7:0]                       cpu_rdata,
    output logic                             mem_req,
    output logic                             mem_we,
    output logic [ADDR_W-OFF_W-1:0]          mem_addr,
    output logic [LINE_W-1:0]                mem_wdata,
    input  logic                             mem_ready,
    input  logic                             mem_rvalid,
    input  logic [LINE_W-1:0]                mem_rdata
);
    localparam int TAG_W = ADDR_W - OFF_W - SET_W;

    logic [SET_W-1:0]            set_idx;
    logic [WAYS-1:0]             rd_valid;
    logic [WAYS-1:0]             rd_dirty;
    logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
    logic                        rd_lru;
    logic [WAYS-1:0][LINE_W-1:0] rd_line;
    logic                        tw_en, tw_way, tw_dirty;
    logic [TAG_W-1:0]            tw_tag;
    logic                        lru_we, lru_val;
    logic                        dw_en, dw_way;
    line_t                       dw_line;

    cache2w_ctrl #(.SET_W(SET_W), .TAG_W(TAG_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .set_idx(set_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
        .rd_lru(rd_lru), .rd_line(rd_line),
        .tw_en(tw_en), .tw_way(tw_way), .tw_tag(tw_tag), .tw_dirty(tw_dirty),
        .lru_we(lru_we), .lru_val(lru_val),
        .dw_en(dw_en), .dw_way(dw_way), .dw_line(dw_line)
    );

    cache2w_tag_store #(.SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst), .set_idx(set_idx),
        .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag), .rd_lru(rd_lru),
        .wr_en(tw_en), .wr_way(tw_way), .wr_tag(tw_tag), .wr_dirty(tw_dirty),
        .lru_we(lru_we), .lru_val(lru_val)
    );

    cache2w_data_store #(.SET_W(SET_W)) u_data (
        .clk(clk), .set_idx(set_idx), .rd_line(rd_line),
        .wr_en(dw_en), .wr_way(dw_way), .wr_line(dw_line)
    );

endmodule

// File: rtl/cache2w_checker.sv
module cache2w_checker
    import cache2w_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    cpu_ready,
    input logic                    cpu_done,
    input logic                    mem_req,
    input logic                    mem_we,
    input logic [ADDR_W-OFF_W-1:0] mem_addr,
    input logic                    mem_ready
);
    // R2: completion is a single-cycle pulse
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> !cpu_done);

    // R2: completion coincides with the return to idle
    p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> cpu_ready);

    // R9: no memory traffic while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !mem_req);

    // R9: request held stable until accepted
    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R8: an accepted write-back is followed at once by the block fetch
    p_wb_then_fetch_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ready) |=> (mem_req && !mem_we));

endmodule

bind cache2w_top cache2w_checker u_checker (
    .clk(clk), .rst(rst), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ready(mem_ready)
);

// File: tb/cache2w_top_test.sv
`timescale 1ns/1ps
module cache2w_top_test;
    localparam int SB = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_ready, cpu_done;
    logic [7:0]  cpu_rdata;
    logic        mem_req, mem_we;
    logic [21:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ready = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0, errors = 0;
    int n_rd = 0, n_wr = 0;
    logic [21:0] last_wr_addr;
    logic [31:0] last_wr_data;
    bit          op_log[$];

    typedef struct { bit we; logic [23:0] a; logic [7:0] exp; } item_t;
    item_t sb[$];

    logic [7:0]  ref_mem [int];
    logic [31:0] bmem [int];

    always #2.5 clk = ~clk;

    cache2w_top #(.SET_W(SB)) uut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] init_byte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [31:0] blk_get(input logic [21:0] b);
        logic [31:0] w;
        if (bmem.exists(int'(b))) return bmem[int'(b)];
        for (int i = 0; i < 4; i++) w[i*8 +: 8] = init_byte({b, i[1:0]});
        return w;
    endfunction

    function automatic logic [7:0] ref_read(input logic [23:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_byte(a);
    endfunction

    function automatic logic [23:0] mk(input int tag, input int set, input int off);
        return 24'((tag << (2 + SB)) | (set << 2) | off);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    int last_lat;
    task automatic access(input bit we, input logic [23:0] a, input logic [7:0] d);
        item_t it;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        it.we = we; it.a = a; it.exp = we ? 8'h00 : ref_read(a);
        if (we) ref_mem[int'(a)] = d;
        sb.push_back(it);
        last_lat = 0;
        do begin
            @(negedge clk);
            cpu_req = 1'b0;
            last_lat++;
        end while (!cpu_done && last_lat < 100);
    endtask

    // memory responder
    initial begin
        logic        c_we;
        logic [21:0] c_addr;
        logic [31:0] c_data;
        forever begin
            @(negedge clk);
            if (mem_req) begin
                c_we = mem_we; c_addr = mem_addr; c_data = mem_wdata;
                @(negedge clk);
                mem_ready = 1'b1;
                @(negedge clk);
                mem_ready = 1'b0;
                op_log.push_back(c_we);
                if (c_we) begin
                    n_wr++;
                    last_wr_addr = c_addr; last_wr_data = c_data;
                    bmem[int'(c_addr)] = c_data;
                end else begin
                    n_rd++;
                    @(negedge clk);
                    mem_rvalid = 1'b1; mem_rdata = blk_get(c_addr);
                    @(negedge clk);
                    mem_rvalid = 1'b0;
                end
            end
        end
    end

    // scoreboard monitor
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (!rst && cpu_done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R2 unexpected completion", 1, 0);
                end else begin
                    it = sb.pop_front();
                    if (!it.we) chk(cpu_rdata == it.exp, "R3 load data", cpu_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int r0, w0;
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1
        chk(cpu_ready == 1'b1, "R1 ready after reset", cpu_ready, 1);
        chk(mem_req == 1'b0, "R1 no mem req after reset", mem_req, 0);
        chk(cpu_done == 1'b0, "R1 no done after reset", cpu_done, 0);

        // R3 cold read miss
        r0 = n_rd; w0 = n_wr;
        access(0, mk(1, 5, 1), 0);
        chk(n_rd - r0 == 1, "R3 one fetch on miss", n_rd - r0, 1);
        chk(n_wr - w0 == 0, "R3 no write on cold miss", n_wr - w0, 0);

        // R2 hit
        r0 = n_rd;
        access(0, mk(1, 5, 3), 0);
        chk(n_rd == r0, "R2 no fetch on hit", n_rd - r0, 0);
        chk(last_lat == 2, "R2 hit latency", last_lat, 2);

        // R4 second way
        r0 = n_rd; w0 = n_wr;
        access(0, mk(2, 5, 0), 0);
        access(0, mk(1, 5, 2), 0);
        access(0, mk(2, 5, 1), 0);
        chk(n_rd - r0 == 1, "R4 both ways resident", n_rd - r0, 1);
        chk(n_wr == w0, "R4 no eviction write", n_wr - w0, 0);

        // R5 LRU: touch tag1 so tag2 is LRU, then tag3 evicts tag2
        access(0, mk(1, 5, 0), 0);
        r0 = n_rd; w0 = n_wr;
        access(0, mk(3, 5, 0), 0);
        chk(n_wr == w0, "R6 clean victim no write", n_wr - w0, 0);
        access(0, mk(1, 5, 1), 0);
        chk(n_rd - r0 == 1, "R5 recent way kept", n_rd - r0, 1);
        access(0, mk(2, 5, 2), 0);
        chk(n_rd - r0 == 2, "R5 LRU way evicted", n_rd - r0, 2);

        // R6 store hit, then R8 dirty eviction (resident: tag1, tag2)
        r0 = n_rd; w0 = n_wr;
        access(1, mk(1, 5, 2), 8'hC3);
        access(0, mk(1, 5, 2), 0);
        chk(n_rd == r0 && n_wr == w0, "R6 store hit no memory traffic", n_rd + n_wr - r0 - w0, 0);
        access(0, mk(2, 5, 0), 0);
        w0 = n_wr;
        access(0, mk(4, 5, 0), 0);
        chk(n_wr - w0 == 1, "R8 dirty victim written", n_wr - w0, 1);
        chk(op_log.size() >= 2 && op_log[op_log.size()-2] == 1'b1 && op_log[op_log.size()-1] == 1'b0,
            "R8 write-back before fetch", op_log.size(), 2);
        chk(last_wr_addr == mk(1, 5, 0) >> 2, "R8 write-back address", last_wr_addr, mk(1, 5, 0) >> 2);
        chk(last_wr_data[23:16] == 8'hC3, "R8 write-back data", last_wr_data[23:16], 8'hC3);
        chk(last_wr_data[7:0] == init_byte(mk(1, 5, 0)), "R8 write-back other byte",
            last_wr_data[7:0], init_byte(mk(1, 5, 0)));
        access(0, mk(1, 5, 2), 0);

        // R7 store miss allocates and merges
        r0 = n_rd; w0 = n_wr;
        access(1, mk(5, 9, 1), 8'h77);
        chk(n_rd - r0 == 1, "R7 store miss fetches", n_rd - r0, 1);
        chk(n_wr == w0, "R7 store miss no write", n_wr - w0, 0);
        for (int i = 0; i < 4; i++) access(0, mk(5, 9, i), 0);
        chk(n_rd - r0 == 1, "R7 merged block resident", n_rd - r0, 1);

        // R10 same tag, neighbouring sets do not conflict
        r0 = n_rd;
        access(0, mk(6, 20, 0), 0);
        access(0, mk(6, 21, 0), 0);
        access(0, mk(6, 22, 0), 0);
        access(0, mk(6, 20, 3), 0);
        access(0, mk(6, 21, 3), 0);
        access(0, mk(6, 22, 3), 0);
        chk(n_rd - r0 == 3, "R10 sets independent", n_rd - r0, 3);

        // mixed pseudo-random traffic, checked by the scoreboard
        lfsr = 16'hACE1;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            access(lfsr[0], mk(8 + int'(lfsr[3:2] % 3), 30 + int'(lfsr[5:4]), int'(lfsr[7:6])),
                   lfsr[15:8]);
        end

        repeat (5) @(negedge clk);
        chk(sb.size() == 0, "R2 all requests completed", sb.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule